// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block chooses, for every channel of a bank of three-channel counter chips, which signal drives the channel's count input and which signal drives its gate input. The chips are organised as three groups of two chips each, which gives eighteen channels. Software programs the choice through byte writes. Each group has one clock selection address and one gate selection address. A single written byte names the chip within the group, the channel within the chip, and a 5-bit source number.

The block also holds the prescaler that produces the fixed-rate clock sources. All rates are derived from the 20 MHz system clock, and each appears as a one-cycle enable pulse rather than as a gated clock. A small control register decides whether the two upper source bits are accepted. When they are not accepted, only sources 0 to 7 can be reached.

The selections are held in registers. The routed outputs are combinational from the held selection, the prescaler pulses and the external clock pins.

Top module: `ctr_src_router`

## Requirements
- R1: After reset every channel uses clock source 0 and gate source 0, so `ch_gate` is all ones and `ch_clk` equals `ext_clk`. The upper source bits are not accepted after reset.
- R2: A write to address 0x18+g (clock) or 0x1B+g (gate), for group g = 0..2, updates a single channel. Its flat index is g*6 + chip*3 + chan, where chip is data bit 5 and chan is data bits 4:3. The source number is {data[7:6], data[2:0]}. No other channel changes.
- R3: A channel whose clock source is 0 drives `ch_clk[i]` from `ext_clk[i]` in the same cycle.
- R4: Gate source 0 drives the channel's gate to 1. Every other gate source drives it to 0.
- R5: Clock sources 1, 2, 3, 4 and 5 each give one-cycle pulses with periods of 2, 20, 200, 2000 and 20000 system cycles. Source 11 is high in every cycle. Every other nonzero source is constant 0.
- R6: Bit 0 of a write to address 0x20 sets enhanced mode. While enhanced mode is off, data bits 7:6 of a selection write are stored as 0.
- R7: A selection write with a channel field of 3 is ignored. A write to any address other than 0x18..0x1D and 0x20 is ignored.
- R8: A new selection drives the outputs from the cycle after the write edge. Without a write, the selections hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 6 | Byte write address |
| wr_data | input | 8 | Byte write data |
| ext_clk | input | 18 | Dedicated external clock input, one per channel |
| ch_clk | output | 18 | Routed clock or enable to each counter channel |
| ch_gate | output | 18 | Routed gate to each counter channel |

## Verification
Routing is tried with alternating and all-ones patterns on the external clock pins, to confirm that untouched channels follow their own pin bit for bit. Each rate source is selected on a channel and the spacing and width of its pulses are measured, which separates the decade stages from one another and from the full-rate source. A byte carrying upper source bits is written with enhanced mode off and again with it on: the first lands on a low-numbered rate and the second on the full-rate or a reserved source. Writes with an illegal channel field or an unused address are shown to leave every output unchanged.

// File: rtl/ctr_src_router.sv
module ctr_src_router #(
  parameter int NGRP = 3,
  parameter int NDEC = 4,
  parameter int FULL_SRC = 11,
  parameter int ADDR_W = 6,
  parameter logic [5:0] CLK_BASE = 6'h18,
  parameter logic [5:0] GATE_BASE = 6'h1B,
  parameter logic [5:0] ENH_ADDR = 6'h20,
  localparam int NCH = NGRP * 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [NCH-1:0]    ext_clk,
  output logic [NCH-1:0]    ch_clk,
  output logic [NCH-1:0]    ch_gate
);

  localparam logic [ADDR_W-1:0] NGRP_A = ADDR_W'(NGRP);

  logic                enh_q;
  logic                half_q;
  logic [3:0]          dec_q [1:NDEC];
  logic [NDEC:0]       tick;

  wire [ADDR_W-1:0] clk_off  = wr_addr - CLK_BASE;
  wire [ADDR_W-1:0] gate_off = wr_addr - GATE_BASE;
  wire              clk_wr   = wr_en && (clk_off < NGRP_A);
  wire              gate_wr  = wr_en && (gate_off < NGRP_A);
  wire [4:0]        new_src  = {enh_q ? wr_data[7:6] : 2'b00, wr_data[2:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) enh_q <= 1'b0;
    else if (wr_en && wr_addr == ENH_ADDR) enh_q <= wr_data[0];

  always_comb begin
    tick[0] = half_q;
    for (int k = 1; k <= NDEC; k++)
      tick[k] = tick[k-1] && (dec_q[k] == 4'd9);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      half_q <= 1'b0;
      for (int k = 1; k <= NDEC; k++) dec_q[k] <= 4'd0;
    end else begin
      half_q <= ~half_q;
      for (int k = 1; k <= NDEC; k++)
        if (tick[k-1]) dec_q[k] <= (dec_q[k] == 4'd9) ? 4'd0 : dec_q[k] + 4'd1;
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] GRP = ADDR_W'(i / 6);
    localparam logic               CHIP = 1'((i / 3) % 2);
    localparam logic [1:0]         CHAN = 2'(i % 3);

    logic [4:0] csel_q, gsel_q;
    wire hit = wr_data[5] == CHIP && wr_data[4:3] == CHAN;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        csel_q <= 5'd0;
        gsel_q <= 5'd0;
      end else begin
        if (clk_wr && hit && clk_off == GRP)   csel_q <= new_src;
        if (gate_wr && hit && gate_off == GRP) gsel_q <= new_src;
      end

    always_comb begin
      ch_clk[i] = 1'b0;
      if (csel_q == 5'd0) ch_clk[i] = ext_clk[i];
      else if (csel_q == 5'(FULL_SRC)) ch_clk[i] = 1'b1;
      else
        for (int k = 0; k <= NDEC; k++)
          if (csel_q == 5'(k + 1)) ch_clk[i] = tick[k];
    end

    assign ch_gate[i] = (gsel_q == 5'd0);
  end

endmodule

// File: rtl/ctr_src_router_chk.sv
module ctr_src_router_chk #(
  parameter int NCH = 18,
  parameter int ADDR_W = 6,
  parameter logic [5:0] GATE_BASE = 6'h1B,
  parameter logic [5:0] ENH_ADDR = 6'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [NCH-1:0]    ch_gate,
  input logic              enh
);

  p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(ch_gate));

  p_bad_chan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4:3] == 2'b11 && wr_addr != ENH_ADDR) |=> $stable(ch_gate));

  p_enh_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ENH_ADDR) |=> enh == $past(wr_data[0]));

  p_gate_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == GATE_BASE && wr_data == 8'h00) |=> ch_gate[0]);

  p_gate_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == GATE_BASE && wr_data == 8'h01) |=> !ch_gate[0]);

endmodule

bind ctr_src_router ctr_src_router_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .GATE_BASE(GATE_BASE), .ENH_ADDR(ENH_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .ch_gate(ch_gate), .enh(enh_q)
);

// File: tb/ctr_src_router_tb.sv
module ctr_src_router_tb;
  localparam int NCH = 18;
  localparam logic [NCH-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [NCH-1:0] ext_clk = '0;
  logic [NCH-1:0] ch_clk, ch_gate;

  int checks = 0;
  int errors = 0;
  logic [NCH-1:0] gmask = '1;

  always #5 clk = ~clk;

  ctr_src_router u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_clk(ext_clk), .ch_clk(ch_clk), .ch_gate(ch_gate)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input string req, input int idx, input int exp_per);
    int t = 0;
    int per = 0;
    while (!ch_clk[idx] && t < 50000) begin @(negedge clk); t++; end
    @(negedge clk);
    per = 1;
    if (exp_per > 1) chk({req, " pulse width"}, 32'(ch_clk[idx]), 32'd0);
    while (!ch_clk[idx] && per < 50000) begin @(negedge clk); per++; end
    chk({req, " period"}, 32'(per), 32'(exp_per));
  endtask

  task automatic t_reset;
    chk("R1 gate reset", 32'(ch_gate), 32'(ONES));
    ext_clk = 18'h2B5C3;
    #1 chk("R1 clk reset follows ext", 32'(ch_clk), 32'(ext_clk));
  endtask

  task automatic t_ext;
    logic [NCH-1:0] pats [4] = '{18'h2AAAA, 18'h15555, 18'h3FFFF, 18'h00000};
    foreach (pats[j]) begin
      @(negedge clk);
      ext_clk = pats[j];
      #1 chk("R3 ext routing", 32'(ch_clk), 32'(pats[j]));
    end
  endtask

  task automatic t_gate;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'h1C; wr_data = 8'h09;
    #1 chk("R8 old gate before edge", 32'(ch_gate), 32'(gmask));
    @(negedge clk);
    wr_en = 1'b0;
    gmask[7] = 1'b0;
    chk("R2 R4 gate idx7 src1", 32'(ch_gate), 32'(gmask));
    wr(6'h1D, 8'h32);
    gmask[17] = 1'b0;
    chk("R2 R4 gate idx17 src2", 32'(ch_gate), 32'(gmask));
    wr(6'h1B, 8'h2B);
    gmask[4] = 1'b0;
    chk("R2 gate idx4 src3", 32'(ch_gate), 32'(gmask));
    wr(6'h1C, 8'h08);
    gmask[7] = 1'b1;
    chk("R4 gate idx7 back to src0", 32'(ch_gate), 32'(gmask));
  endtask

  task automatic t_ignored;
    ext_clk = 18'h3C3C3;
    wr(6'h1B, 8'h19);
    chk("R7 gate chan3 ignored", 32'(ch_gate), 32'(gmask));
    wr(6'h18, 8'h1D);
    chk("R7 clk chan3 ignored", 32'(ch_clk), 32'(ext_clk));
    wr(6'h1E, 8'h01);
    chk("R7 addr 1E ignored gate", 32'(ch_gate), 32'(gmask));
    wr(6'h17, 8'h01);
    chk("R7 addr 17 ignored clk", 32'(ch_clk), 32'(ext_clk));
  endtask

  task automatic t_rates;
    ext_clk = '0;
    wr(6'h18, 8'h01);
    chk("R2 only idx0 changes", 32'(ch_clk[17:1]), 32'd0);
    measure("R5 src1", 0, 2);
    wr(6'h18, 8'h02);
    measure("R5 src2", 0, 20);
    wr(6'h18, 8'h03);
    measure("R5 src3", 0, 200);
    wr(6'h1A, 8'h04);
    measure("R5 R2 src4 idx12", 12, 2000);
    wr(6'h18, 8'h05);
    measure("R5 src5", 0, 20000);
    wr(6'h18, 8'h06);
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (ch_clk[0]) begin chk("R5 src6 constant 0", 32'd1, 32'd0); break; end
    end
    chk("R5 src6 low at end", 32'(ch_clk[0]), 32'd0);
  endtask

  task automatic t_enh;
    wr(6'h18, 8'h43);
    measure("R6 basic mode drops upper bits", 0, 200);
    wr(6'h20, 8'h01);
    wr(6'h18, 8'h43);
    for (int n = 0; n < 5; n++) begin
      chk("R5 R6 src11 full rate", 32'(ch_clk[0]), 32'd1);
      @(negedge clk);
    end
    wr(6'h18, 8'h44);
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (ch_clk[0]) begin chk("R5 src12 reserved", 32'd1, 32'd0); break; end
    end
    chk("R5 src12 low at end", 32'(ch_clk[0]), 32'd0);
    wr(6'h1B, 8'h40);
    gmask[0] = 1'b0;
    chk("R4 R6 gate src8 enhanced", 32'(ch_gate), 32'(gmask));
    wr(6'h20, 8'h00);
    wr(6'h1B, 8'h40);
    gmask[0] = 1'b1;
    chk("R6 basic gate src8 becomes 0", 32'(ch_gate), 32'(gmask));
    wr(6'h18, 8'h81);
    measure("R6 basic 0x81 is src1", 0, 2);
  endtask

  initial begin
    #2 rst_n = 1'b0;
    #20 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ext();
    t_gate();
    t_ignored();
    t_rates();
    t_enh();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule